// File: doc/BRIEF.md
# Ping-Pong Audio Sample Fetcher

This block pulls audio samples out of memory on behalf of a serial audio output stage. Software hands it two buffers, each identified by a base address, and one common length. The block reads sample data from the active buffer in order, over a request/grant read port. It then presents complete left/right pairs to the consumer through a valid/ready handshake.

Fetches are 32 bits wide, where one word carries both channels, or 16 bits wide, where two successive reads make one pair. When the last read of the active buffer is granted, the block moves straight to the other buffer. At the same time it drops the spent buffer's loaded flag and raises that buffer's refill request. Software answers the request by writing a new base address for the spent buffer, which marks it loaded again.

If the block turns to a buffer that has not been reloaded, it stops issuing reads and flags an underrun. It resumes on its own from the start of that buffer once software loads it.

Top module: `pingpong_sample_fetch`

## Requirements
- R1: After reset, `mem_req`, `smp_valid`, `buf_full`, `refill_irq`, `active_buf` and `underrun` are all zero.
- R2: A write (`cfg_wr`) to buffer `cfg_sel` whose loaded flag is clear stores `cfg_base`, sets `buf_full[cfg_sel]` and clears `refill_irq[cfg_sel]` on the next clock edge. A write to a buffer whose flag is already set has no effect, on either its flag or the addresses it is later read from.
- R3: `mem_req` is high exactly when `run_en` is high, the active buffer's flag is set and no pair is waiting at the output. `mem_addr` equals the active base plus an offset. The offset starts at 0 and grows by 4 per granted read in 32-bit mode and by 2 in 16-bit mode. While a request waits for `mem_gnt`, the address holds.
- R4: With `word_mode`=1, each granted read yields one pair: left = `mem_rdata[15:0]`, right = `mem_rdata[31:16]`.
- R5: With `word_mode`=0, only `mem_rdata[15:0]` is used. The first of two granted reads gives the left sample and the second gives the right sample.
- R6: `buf_len` counts pairs, and must be 1 or more. After `buf_len` grants (32-bit mode) or 2*`buf_len` grants (16-bit mode), the block does three things on the next edge. `active_buf` toggles, the spent buffer's `buf_full` bit clears, and its `refill_irq` bit sets. The next read starts at offset 0 of the other buffer. `refill_irq` bits stay set until the matching buffer is reloaded.
- R7: `underrun` is high exactly when `run_en` is high and the active buffer's flag is clear; no read is requested then. Reloading that buffer resumes reads from its base.
- R8: `smp_valid` with `smp_left`/`smp_right` holds unchanged until a cycle with `smp_ready` high, and drops after that edge.
- R9: While `run_en` is low, no read is requested and all fetch state holds.
- R10: A reload of the idle buffer in the same cycle as the grant that exhausts the active buffer takes effect. Reads continue from the reloaded buffer with no underrun cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Allows fetching |
| word_mode | input | 1 | 1: 32-bit fetches, 0: 16-bit fetches |
| buf_len | input | LEN_W | Buffer length in sample pairs |
| cfg_wr | input | 1 | Base address write strobe |
| cfg_sel | input | 1 | Buffer addressed by the write |
| cfg_base | input | ADDR_W | Base address written |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_gnt | input | 1 | Read granted; data valid this cycle |
| mem_rdata | input | 2*SMP_W | Read data |
| smp_valid | output | 1 | Pair available |
| smp_ready | input | 1 | Consumer takes the pair |
| smp_left | output | SMP_W | Left sample |
| smp_right | output | SMP_W | Right sample |
| buf_full | output | 2 | Loaded flag per buffer |
| refill_irq | output | 2 | Refill request per buffer |
| active_buf | output | 1 | Buffer being read |
| underrun | output | 1 | Stalled on an unloaded buffer |

## Verification
The critical overlap is the grant that finishes the active buffer arriving in the same cycle as software's reload of the other, idle buffer. The switch and the flag set then land on one edge. The bench's random refill policy spots the cycle in which it grants that final read and, half of the time, writes the idle buffer's base right then. In the following cycle it requires `underrun` low and a request already aimed at the new base. Collisions of a write with a buffer that is still loaded, including the one being spent, are judged by the addresses of the later reads.

// File: rtl/pps_fetch_pkg.sv
package pps_fetch_pkg;

   localparam int unsigned NUM_BUFS = 2;

   typedef enum logic {
      FMT_HALF = 1'b0,
      FMT_WORD = 1'b1
   } fetch_fmt_e;

   // bytes consumed by one read in the given format
   function automatic int unsigned fetch_bytes(fetch_fmt_e fmt, int unsigned smp_w);
      return (fmt == FMT_WORD) ? (2 * smp_w) / 8 : smp_w / 8;
   endfunction

endpackage

// File: rtl/pps_bank.sv
module pps_bank
   import pps_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned NBUF   = NUM_BUFS
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_i,
   input  logic [$clog2(NBUF)-1:0]     wr_sel_i,
   input  logic [ADDR_W-1:0]           wr_base_i,
   input  logic                        spend_i,
   input  logic [$clog2(NBUF)-1:0]     spend_idx_i,
   output logic [NBUF-1:0][ADDR_W-1:0] base_o,
   output logic [NBUF-1:0]             full_o,
   output logic [NBUF-1:0]             irq_o
);

   localparam int unsigned IDX_W = $clog2(NBUF);

   for (genvar g = 0; g < NBUF; g++) begin : g_buf
      logic hit_wr;
      logic hit_spend;
      logic accept;

      assign hit_wr    = wr_i && (wr_sel_i == IDX_W'(g));
      assign hit_spend = spend_i && (spend_idx_i == IDX_W'(g));
      assign accept    = hit_wr && !full_o[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_o[g] <= '0;
            full_o[g] <= 1'b0;
            irq_o[g]  <= 1'b0;
         end else begin
            if (accept) begin
               base_o[g] <= wr_base_i;
            end
            if (hit_spend) begin
               full_o[g] <= 1'b0;
               irq_o[g]  <= 1'b1;
            end else if (accept) begin
               full_o[g] <= 1'b1;
               irq_o[g]  <= 1'b0;
            end
         end
      end

      // R6
      full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(full_o[g]) |-> $past(spend_i && spend_idx_i == IDX_W'(g)));

      // R2
      full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(full_o[g]) |-> $past(wr_i && wr_sel_i == IDX_W'(g)));
   end

endmodule

// File: rtl/pps_walker.sv
module pps_walker
   import pps_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned SMP_W  = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            adv_i,
   input  fetch_fmt_e                      fmt_i,
   input  logic [LEN_W-1:0]                len_i,
   input  logic [NUM_BUFS-1:0][ADDR_W-1:0] base_i,
   output logic                            act_o,
   output logic [ADDR_W-1:0]               addr_o,
   output logic                            spend_o
);

   localparam int unsigned CNT_W = LEN_W + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  reads;
   logic [ADDR_W-1:0] off_q;
   logic [ADDR_W-1:0] step;
   logic              last;

   always_comb begin
      reads   = (fmt_i == FMT_WORD) ? {1'b0, len_i} : {len_i, 1'b0};
      step    = ADDR_W'(fetch_bytes(fmt_i, SMP_W));
      last    = (cnt_q == reads - CNT_W'(1));
      addr_o  = base_i[act_o] + off_q;
      spend_o = adv_i && last;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         off_q <= '0;
         act_o <= 1'b0;
      end else if (adv_i) begin
         if (last) begin
            cnt_q <= '0;
            off_q <= '0;
            act_o <= ~act_o;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            off_q <= off_q + step;
         end
      end
   end

   // R6
   buf_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && last) |=> (act_o != $past(act_o)) && (off_q == '0));

   // R3
   walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(off_q) && $stable(act_o));

endmodule

// File: rtl/pps_packer.sv
module pps_packer
   import pps_fetch_pkg::*;
#(
   parameter int unsigned SMP_W    = 16,
   parameter bit          LEFT_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  fetch_fmt_e         fmt_i,
   input  logic [2*SMP_W-1:0] rdata_i,
   input  logic               ready_i,
   output logic               valid_o,
   output logic [SMP_W-1:0]   left_o,
   output logic [SMP_W-1:0]   right_o
);

   logic [SMP_W-1:0] lane_lo;
   logic [SMP_W-1:0] lane_hi;
   logic [SMP_W-1:0] word_left;
   logic [SMP_W-1:0] word_right;
   logic [SMP_W-1:0] hold_q;
   logic             half_q;

   assign lane_lo = rdata_i[SMP_W-1:0];
   assign lane_hi = rdata_i[2*SMP_W-1:SMP_W];

   if (LEFT_LOW) begin : g_left_low
      assign word_left  = lane_lo;
      assign word_right = lane_hi;
   end else begin : g_left_high
      assign word_left  = lane_hi;
      assign word_right = lane_lo;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         left_o  <= '0;
         right_o <= '0;
         hold_q  <= '0;
         half_q  <= 1'b0;
      end else begin
         if (valid_o && ready_i) begin
            valid_o <= 1'b0;
         end
         if (take_i) begin
            if (fmt_i == FMT_WORD) begin
               left_o  <= word_left;
               right_o <= word_right;
               valid_o <= 1'b1;
            end else if (!half_q) begin
               hold_q <= lane_lo;
               half_q <= 1'b1;
            end else begin
               left_o  <= hold_q;
               right_o <= lane_lo;
               valid_o <= 1'b1;
               half_q  <= 1'b0;
            end
         end
      end
   end

   // R8
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ready_i) |=> valid_o && $stable(left_o) && $stable(right_o));

   // R8
   no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> !valid_o);

endmodule

// File: rtl/pingpong_sample_fetch.sv
module pingpong_sample_fetch
   import pps_fetch_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned LEN_W    = 8,
   parameter int unsigned SMP_W    = 16,
   parameter bit          LEFT_LOW = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic               word_mode,
   input  logic [LEN_W-1:0]   buf_len,
   input  logic               cfg_wr,
   input  logic               cfg_sel,
   input  logic [ADDR_W-1:0]  cfg_base,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_gnt,
   input  logic [2*SMP_W-1:0] mem_rdata,
   output logic               smp_valid,
   input  logic               smp_ready,
   output logic [SMP_W-1:0]   smp_left,
   output logic [SMP_W-1:0]   smp_right,
   output logic [1:0]         buf_full,
   output logic [1:0]         refill_irq,
   output logic               active_buf,
   output logic               underrun
);

   initial begin
      if (SMP_W < 8 || (SMP_W % 8) != 0) $fatal(1, "SMP_W must be a whole number of bytes");
      if (LEN_W < 1) $fatal(1, "LEN_W must be at least 1");
      if (ADDR_W < 8) $fatal(1, "ADDR_W too narrow");
   end

   fetch_fmt_e                      fmt;
   logic [NUM_BUFS-1:0][ADDR_W-1:0] bases;
   logic                            take;
   logic                            spend;
   logic                            act_loaded;

   assign fmt        = fetch_fmt_e'(word_mode);
   assign act_loaded = buf_full[active_buf];
   assign mem_req    = run_en && act_loaded && !smp_valid;
   assign underrun   = run_en && !act_loaded;
   assign take       = mem_req && mem_gnt;

   pps_bank #(
      .ADDR_W (ADDR_W),
      .NBUF   (NUM_BUFS)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (cfg_wr),
      .wr_sel_i    (cfg_sel),
      .wr_base_i   (cfg_base),
      .spend_i     (spend),
      .spend_idx_i (active_buf),
      .base_o      (bases),
      .full_o      (buf_full),
      .irq_o       (refill_irq)
   );

   pps_walker #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .SMP_W  (SMP_W)
   ) u_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv_i   (take),
      .fmt_i   (fmt),
      .len_i   (buf_len),
      .base_i  (bases),
      .act_o   (active_buf),
      .addr_o  (mem_addr),
      .spend_o (spend)
   );

   pps_packer #(
      .SMP_W    (SMP_W),
      .LEFT_LOW (LEFT_LOW)
   ) u_packer (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .fmt_i   (fmt),
      .rdata_i (mem_rdata),
      .ready_i (smp_ready),
      .valid_o (smp_valid),
      .left_o  (smp_left),
      .right_o (smp_right)
   );

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && run_en) |=> (!run_en || (mem_req && $stable(mem_addr))));

   for (genvar g = 0; g < 2; g++) begin : g_irq_chk
      // R6
      irq_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(refill_irq[g]) |-> ($past(active_buf) == 1'(g)) && (active_buf != 1'(g)));
   end

endmodule

// File: tb/pingpong_sample_fetch_tb.sv
module pingpong_sample_fetch_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        word_mode = 1'b1;
   logic [7:0]  buf_len = 8'd1;
   logic        cfg_wr = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_base = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_gnt = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        smp_valid;
   logic        smp_ready = 1'b0;
   logic [15:0] smp_left;
   logic [15:0] smp_right;
   logic [1:0]  buf_full;
   logic [1:0]  refill_irq;
   logic        active_buf;
   logic        underrun;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pingpong_sample_fetch u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .word_mode  (word_mode),
      .buf_len    (buf_len),
      .cfg_wr     (cfg_wr),
      .cfg_sel    (cfg_sel),
      .cfg_base   (cfg_base),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_gnt    (mem_gnt),
      .mem_rdata  (mem_rdata),
      .smp_valid  (smp_valid),
      .smp_ready  (smp_ready),
      .smp_left   (smp_left),
      .smp_right  (smp_right),
      .buf_full   (buf_full),
      .refill_irq (refill_irq),
      .active_buf (active_buf),
      .underrun   (underrun)
   );

   int n_chk = 0;
   int n_err = 0;

   // reference model
   logic [31:0] exp_base [2];
   logic [1:0]  exp_full;
   logic [1:0]  exp_irq;
   logic        exp_act;
   int          exp_rd;
   logic [15:0] half_left;
   logic [31:0] exp_q [$];

   // stimulus controls
   logic        en_cmd = 1'b0;
   int          gnt_pct = 100;
   int          ready_pct = 100;
   bit          auto_refill = 1'b0;
   bit          wr_pend = 1'b0;
   logic        wr_pend_sel = 1'b0;
   logic [31:0] wr_pend_base = '0;
   bit          coin_pending = 1'b0;
   int          coin_cnt = 0;

   function automatic logic [31:0] data_of(logic [31:0] a);
      return {a[15:0] ^ 16'hC3A1, a[15:0] + 16'h1357};
   endfunction

   function automatic int step_bytes();
      return word_mode ? 4 : 2;
   endfunction

   function automatic int reads_per_buf();
      return word_mode ? int'(buf_len) : 2 * int'(buf_len);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      exp_base[0] = '0;
      exp_base[1] = '0;
      exp_full    = '0;
      exp_irq     = '0;
      exp_act     = 1'b0;
      exp_rd      = 0;
      half_left   = '0;
      exp_q.delete();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      en_cmd = 1'b0;
      run_en = 1'b0;
      cfg_wr = 1'b0;
      mem_gnt = 1'b0;
      smp_ready = 1'b0;
      wr_pend = 1'b0;
      coin_pending = 1'b0;
      repeat (3) @(negedge clk);
      model_clear();
      rst_n = 1'b1;
   endtask

   // one clock of stimulus and checking, all away from the rising edge
   task automatic cycle();
      logic [1:0]  full_pre;
      logic [31:0] ea;
      logic [31:0] nb;
      bit          last_now;
      bit          do_wr;
      logic        wsel;
      logic [31:0] wbase;
      @(negedge clk);
      run_en = en_cmd;
      #1;
      // state checks against the model
      chk("R7 underrun", 32'(underrun), 32'(en_cmd && !exp_full[exp_act]));
      chk("R6 buf_full", 32'(buf_full), 32'(exp_full));
      chk("R6 refill_irq", 32'(refill_irq), 32'(exp_irq));
      chk("R6 active_buf", 32'(active_buf), 32'(exp_act));
      chk("R8 smp_valid", 32'(smp_valid), 32'(exp_q.size() > 0));
      if (!en_cmd) chk("R9 mem_req idle", 32'(mem_req), 32'd0);
      else chk("R3 mem_req", 32'(mem_req), 32'(exp_full[exp_act] && exp_q.size() == 0));
      if (coin_pending) begin
         chk("R10 no underrun after coincident reload", 32'(underrun), 32'd0);
         coin_pending = 1'b0;
      end
      // consumer side
      smp_ready = (($urandom % 100) < ready_pct);
      if (smp_valid && smp_ready && exp_q.size() > 0) begin
         chk(word_mode ? "R4 pair" : "R5 pair", {smp_right, smp_left}, exp_q[0]);
         void'(exp_q.pop_front());
      end
      // memory side
      full_pre = exp_full;
      last_now = 1'b0;
      mem_gnt  = 1'b0;
      if (mem_req && (($urandom % 100) < gnt_pct)) begin
         mem_gnt   = 1'b1;
         mem_rdata = data_of(mem_addr);
         ea = exp_base[exp_act] + 32'(exp_rd * step_bytes());
         chk("R3 mem_addr", mem_addr, ea);
         if (word_mode) exp_q.push_back(data_of(ea));
         else if ((exp_rd % 2) == 0) half_left = data_of(ea)[15:0];
         else exp_q.push_back({data_of(ea)[15:0], half_left});
         exp_rd++;
         if (exp_rd == reads_per_buf()) begin
            exp_full[exp_act] = 1'b0;
            exp_irq[exp_act]  = 1'b1;
            exp_act = ~exp_act;
            exp_rd  = 0;
            last_now = 1'b1;
         end
      end
      // software side
      do_wr = 1'b0;
      wsel  = 1'b0;
      wbase = '0;
      nb = 32'h0001_0000 + (($urandom % 256) << 8);
      if (wr_pend) begin
         do_wr = 1'b1;
         wsel  = wr_pend_sel;
         wbase = wr_pend_base;
         wr_pend = 1'b0;
      end else if (auto_refill) begin
         if (last_now && !full_pre[exp_act] && ($urandom % 2) == 0) begin
            do_wr = 1'b1;
            wsel  = exp_act;
            wbase = nb;
            coin_pending = 1'b1;
            coin_cnt++;
         end else if (($urandom % 6) == 0) begin
            for (int b = 0; b < 2; b++) begin
               if (!do_wr && exp_irq[b] && !full_pre[b]) begin
                  do_wr = 1'b1;
                  wsel  = 1'(b);
                  wbase = nb;
               end
            end
         end
      end
      cfg_wr   = do_wr;
      cfg_sel  = wsel;
      cfg_base = wbase;
      if (do_wr && !full_pre[wsel]) begin
         exp_full[wsel] = 1'b1;
         exp_irq[wsel]  = 1'b0;
         exp_base[wsel] = wbase;
      end
   endtask

   task automatic wr_base(logic sel, logic [31:0] base);
      wr_pend      = 1'b1;
      wr_pend_sel  = sel;
      wr_pend_base = base;
      cycle();
   endtask

   task automatic drain(int max_cycles);
      for (int i = 0; i < max_cycles; i++) begin
         if (exp_full == 2'b00 && exp_q.size() == 0) break;
         cycle();
      end
      cycle();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      model_clear();
      do_reset();

      // R1: reset state
      @(negedge clk);
      #1;
      chk("R1 mem_req", 32'(mem_req), 32'd0);
      chk("R1 smp_valid", 32'(smp_valid), 32'd0);
      chk("R1 buf_full", 32'(buf_full), 32'd0);
      chk("R1 refill_irq", 32'(refill_irq), 32'd0);
      chk("R1 active_buf", 32'(active_buf), 32'd0);
      chk("R1 underrun", 32'(underrun), 32'd0);

      // R7: enabled with nothing loaded stalls
      en_cmd = 1'b1;
      repeat (3) cycle();
      chk("R7 underrun with empty buffers", 32'(underrun), 32'd1);
      en_cmd = 1'b0;

      // R2, R3, R4, R6: 32-bit directed run, second write to buffer 0 ignored
      word_mode = 1'b1;
      buf_len   = 8'd3;
      wr_base(1'b0, 32'h0000_1000);
      wr_base(1'b0, 32'h0000_2000);
      chk("R2 flag after ignored write", 32'(buf_full), 32'b01);
      wr_base(1'b1, 32'h0000_3000);
      en_cmd = 1'b1;
      drain(200);
      chk("R6 both refill requests", 32'(refill_irq), 32'b11);
      chk("R7 underrun after both spent", 32'(underrun), 32'd1);

      // R7: reload of the stalled buffer resumes from its base
      wr_base(1'b0, 32'h0000_4000);
      drain(200);
      chk("R6 active after resume", 32'(active_buf), 32'd1);

      // R9: disabled block issues nothing
      en_cmd = 1'b0;
      wr_base(1'b1, 32'h0000_5000);
      repeat (8) cycle();
      chk("R9 no request while disabled", 32'(mem_req), 32'd0);
      en_cmd = 1'b1;
      drain(200);

      // R5: 16-bit directed run with stalls on both sides
      do_reset();
      word_mode = 1'b0;
      buf_len   = 8'd2;
      gnt_pct   = 70;
      ready_pct = 40;
      wr_base(1'b0, 32'h0000_0100);
      wr_base(1'b1, 32'h0000_0200);
      en_cmd = 1'b1;
      drain(300);

      // random phases in both formats with reloads and coincidences (R10)
      for (int ph = 0; ph < 4; ph++) begin
         do_reset();
         word_mode   = ph[0];
         buf_len     = 8'(1 + ($urandom % 5));
         gnt_pct     = 50 + int'($urandom % 50);
         ready_pct   = 40 + int'($urandom % 60);
         auto_refill = 1'b0;
         wr_base(1'b0, 32'h0002_0000 + (($urandom % 64) << 8));
         wr_base(1'b1, 32'h0003_0000 + (($urandom % 64) << 8));
         auto_refill = 1'b1;
         en_cmd = 1'b1;
         repeat (4000) cycle();
         auto_refill = 1'b0;
      end
      chk("R10 coincident reloads exercised", 32'(coin_cnt > 0), 32'd1);

      finish_run();
   end

endmodule